// File: doc/BRIEF.md
# Multi-Channel Prescaled Pulse-Width Modulator

This block generates several independent pulse-width modulated outputs from one module clock. Each channel owns a single 32-bit control word that packs three things: a run flag, a high-time count and a clock divider. The divider sets how many module clocks make up one divided tick. An 8-bit phase counter advances once per divided tick, so every output period is exactly 256 divided ticks long. The output is high while the phase is below the high-time count.

Software reaches the control words through a simple request port. A valid strobe and a write flag select the access. The channel is chosen by the address bits just above the 16-byte slot. Read data comes back on the cycle after a read request. When a channel is already running, a change to its high-time or divider does not take effect at once. It waits for the start of the next 256-tick period, so no period is ever cut short or stretched. A parameter sets the channel count, so the same code also serves a single-channel build.

Top module: `pwm_multichan`

## Requirements
- R1: The control word holds the run flag at bit 31, a 9-bit high-time count at bits 24:16 and a 13-bit divider at bits 12:0. A read returns the last written word with all other bits zero, and the data appears on `rsp_rdata` on the cycle after the read request.
- R2: Address bits [4 +: index width] pick the channel, so channels sit 16 bytes apart and address bits 3:0 are ignored. If the address names a channel index that does not exist, a write changes nothing and a read returns zero.
- R3: Within each 256-tick period, a running channel is high for min(count, 256) ticks, starting at phase 0. A count of 0 keeps the output low, and a count of 256 or more keeps it high.
- R4: Each phase step lasts (divider + 1) module clocks, so one period is 256 × (divider + 1) clocks. A divider of 0 advances the phase on every clock.
- R5: A write that sets bit 31 on a stopped channel restarts it at phase 0 with the new count and divider. From the next cycle the output shows phase 0.
- R6: A write with bit 31 clear stops the channel, and its output is low from the next cycle on. Writing all zeros also clears the count and divider fields.
- R7: A write with bit 31 set to a running channel keeps it running. The new count and divider are used only from the next period boundary, and the period already in progress finishes with the old values.
- R8: Channels are independent: traffic to one channel never changes the output or stored word of another.
- R9: After reset every control word reads zero and every output is low.
- R10: The parameter `NUM_CH` sets the channel count; with `NUM_CH` = 1 the single channel at offset 0 works and offset 0x10 does not exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read, qualified by `req_valid` |
| req_addr | input | ADDR_W | Byte address of the control word |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
A phase counter that drifts or a divider counter that miscounts changes the number of high cycles in a period. It also moves the rising edge away from a multiple of 256 × (divider + 1). The bench counts high samples over whole periods, so either fault shows within one period. An active copy that is reloaded too early shows up inside the period where a running channel is updated: the rest of that period should stay at the old high time, and the fault becomes visible within the remaining phases. A wrongly stored control word or a bad channel decode shows up on the next read, and the bound assertions catch a missed stop or start on the cycle after the write.

// File: rtl/pwm_pkg.sv
// Package: shared field positions and helpers for the modulator.
// Assumes a 32-bit control word with the run flag at the top bit.
package pwm_pkg;

    localparam int CTL_W          = 32;
    localparam int EN_POS         = 31;
    localparam int DUTY_POS       = 16;
    localparam int DIV_POS        = 0;
    localparam int DUTY_W_DEF     = 9;
    localparam int DIV_W_DEF      = 13;
    localparam int PHASE_W_DEF    = 8;
    localparam int CH_STRIDE_LOG2 = 4;

    // Builds the mask of implemented bits in a control word.
    function automatic logic [CTL_W-1:0] ctl_mask(int duty_w, int div_w);
        logic [CTL_W-1:0] m;
        m = '0;
        m[EN_POS] = 1'b1;
        for (int i = 0; i < duty_w; i++) m[DUTY_POS + i] = 1'b1;
        for (int i = 0; i < div_w; i++)  m[DIV_POS + i]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pwm_ctl_regs.sv
// Control word storage and access decode.
// Holds one masked word per channel and decodes the channel index from the
// address bits above the 16-byte slot. It flags the write that starts a
// stopped channel and returns read data one cycle after the request.
// Assumes req_valid is a single-cycle strobe.
module pwm_ctl_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DUTY_W = DUTY_W_DEF,
    parameter int DIV_W  = DIV_W_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [CTL_W-1:0]               req_wdata,
    output logic [CTL_W-1:0]               rsp_rdata,
    output logic [NUM_CH-1:0]              ch_en,
    output logic [NUM_CH-1:0]              ch_start,
    output logic [NUM_CH-1:0][DUTY_W-1:0]  ch_duty,
    output logic [NUM_CH-1:0][DIV_W-1:0]   ch_div,
    output logic [DUTY_W-1:0]              wr_duty,
    output logic [DIV_W-1:0]               wr_div
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [CTL_W-1:0] MASK = ctl_mask(DUTY_W, DIV_W);

    logic [IDX_W-1:0]             idx;
    logic [NUM_CH-1:0]            sel;
    logic [CTL_W-1:0]             wr_word;
    logic [CTL_W-1:0]             rd_word;
    logic [NUM_CH-1:0][CTL_W-1:0] ctl_q;

    // Channel index from the address, low slot bits dropped.
    assign idx     = IDX_W'(req_addr >> CH_STRIDE_LOG2);
    // Write data with unimplemented bits forced to zero.
    assign wr_word = req_wdata & MASK;
    assign wr_duty = wr_word[DUTY_POS +: DUTY_W];
    assign wr_div  = wr_word[DIV_POS +: DIV_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Decode: this channel is addressed.
        assign sel[c] = (idx == IDX_W'(c));

        // Stores the masked control word on a write to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[c] <= '0;
            end else if (req_valid && req_write && sel[c]) begin
                ctl_q[c] <= wr_word;
            end
        end

        assign ch_en[c]    = ctl_q[c][EN_POS];
        assign ch_duty[c]  = ctl_q[c][DUTY_POS +: DUTY_W];
        assign ch_div[c]   = ctl_q[c][DIV_POS +: DIV_W];
        // Start pulse: run flag written to a stopped channel.
        assign ch_start[c] = req_valid && req_write && sel[c]
                             && wr_word[EN_POS] && !ctl_q[c][EN_POS];
    end

    // Read mux; an index with no channel reads zero.
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) rd_word = ctl_q[c];
        end
    end

    // Registers read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (req_valid && !req_write) begin
            rsp_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/pwm_prescaler.sv
// Clock divider for one channel.
// Emits a one-cycle tick every (div_val + 1) clocks while the channel runs.
// A start or a stop clears the count so that the first tick follows a
// restart after exactly (div_val + 1) clocks.
module pwm_prescaler #(
    parameter int DIV_W = pwm_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Tick when the count has reached the divider value.
    assign tick = run && !restart && (cnt >= div_val);

    // Counts clocks between ticks, cleared on start, stop and tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_phase_gen.sv
// Phase counter, active value copies and comparator for one channel.
// The phase advances on each divided tick and wraps every 2**PHASE_W ticks.
// The stored high-time and divider are copied into the active registers
// only at the wrap, or directly from write data on a restart. The output
// is high while the phase is below the active high-time.
// Assumes DUTY_W > PHASE_W so that a full-period count is representable.
module pwm_phase_gen #(
    parameter int PHASE_W = pwm_pkg::PHASE_W_DEF,
    parameter int DUTY_W  = pwm_pkg::DUTY_W_DEF,
    parameter int DIV_W   = pwm_pkg::DIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [DUTY_W-1:0] new_duty,
    input  logic [DIV_W-1:0]  new_div,
    input  logic [DUTY_W-1:0] shd_duty,
    input  logic [DIV_W-1:0]  shd_div,
    output logic [DIV_W-1:0]  act_div,
    output logic              pwm
);

    logic [PHASE_W-1:0] phase;
    logic [DUTY_W-1:0]  act_duty;
    logic               wrap;

    // Last tick of a period.
    assign wrap = tick && (phase == {PHASE_W{1'b1}});

    // Advances the phase and reloads the active copies at period edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            act_duty <= '0;
            act_div  <= '0;
        end else if (restart) begin
            phase    <= '0;
            act_duty <= new_duty;
            act_div  <= new_div;
        end else if (!run) begin
            phase    <= '0;
        end else if (tick) begin
            phase <= phase + 1'b1;
            if (wrap) begin
                act_duty <= shd_duty;
                act_div  <= shd_div;
            end
        end
    end

    // Comparator, gated low while stopped.
    assign pwm = run && (DUTY_W'(phase) < act_duty);

endmodule

// File: rtl/pwm_multichan.sv
// Top level: multi-channel prescaled pulse-width modulator.
// One control-word store serves NUM_CH channels, each with its own divider
// and phase generator. Outputs are driven straight from registered state.
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_multichan
    import pwm_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int ADDR_W  = 8,
    parameter int DUTY_W  = DUTY_W_DEF,
    parameter int DIV_W   = DIV_W_DEF,
    parameter int PHASE_W = PHASE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0]             ch_start;
    logic [NUM_CH-1:0][DUTY_W-1:0] ch_duty;
    logic [NUM_CH-1:0][DIV_W-1:0]  ch_div;
    logic [DUTY_W-1:0]             wr_duty;
    logic [DIV_W-1:0]              wr_div;

    pwm_ctl_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DUTY_W (DUTY_W),
        .DIV_W  (DIV_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .ch_en     (ch_en),
        .ch_start  (ch_start),
        .ch_duty   (ch_duty),
        .ch_div    (ch_div),
        .wr_duty   (wr_duty),
        .wr_div    (wr_div)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic             tick;
        logic [DIV_W-1:0] act_div;

        pwm_prescaler #(
            .DIV_W (DIV_W)
        ) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (ch_en[c]),
            .restart (ch_start[c]),
            .div_val (act_div),
            .tick    (tick)
        );

        pwm_phase_gen #(
            .PHASE_W (PHASE_W),
            .DUTY_W  (DUTY_W),
            .DIV_W   (DIV_W)
        ) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (ch_en[c]),
            .restart  (ch_start[c]),
            .tick     (tick),
            .new_duty (wr_duty),
            .new_div  (wr_div),
            .shd_duty (ch_duty[c]),
            .shd_div  (ch_div[c]),
            .act_div  (act_div),
            .pwm      (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwm_multichan_chk.sv
// Checker bound to the modulator top: relates bus writes to outputs.
// Decodes the channel index on its own from the address.
module pwm_multichan_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DUTY_W = DUTY_W_DEF,
    parameter int DIV_W  = DIV_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rsp_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] ch_en
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [31:0] MASK = ctl_mask(DUTY_W, DIV_W);

    logic [IDX_W-1:0]  a_idx;
    logic [DUTY_W-1:0] a_duty;

    assign a_idx  = IDX_W'(req_addr >> CH_STRIDE_LOG2);
    assign a_duty = req_wdata[DUTY_POS +: DUTY_W];

    AST_RDATA_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata & ~MASK) == 32'd0); // R1

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic hit;
        assign hit = req_valid && req_write && (a_idx == IDX_W'(c));

        AST_START_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && req_wdata[EN_POS] && !ch_en[c] && a_duty != '0) |=> pwm_out[c]); // R5

        AST_ZERO_COUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && req_wdata[EN_POS] && !ch_en[c] && a_duty == '0) |=> !pwm_out[c]); // R3

        AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !req_wdata[EN_POS]) |=> !pwm_out[c]); // R6

        AST_STAY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && req_wdata[EN_POS] && ch_en[c]) |=> ch_en[c]); // R7
    end

endmodule

bind pwm_multichan pwm_multichan_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DUTY_W (DUTY_W),
    .DIV_W  (DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .pwm_out   (pwm_out),
    .ch_en     (ch_en)
);

// File: tb/sim_pwm_multichan.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor compares
// them with measured results as they arrive.
module sim_pwm_multichan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;

    logic        a_valid = 1'b0, a_write = 1'b0;
    logic [7:0]  a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic [3:0]  a_out;

    logic        b_valid = 1'b0, b_write = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [0:0]  b_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    string       tag_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];

    always #10 clk = ~clk;

    pwm_multichan #(.NUM_CH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_write(a_write),
        .req_addr(a_addr), .req_wdata(a_wdata), .rsp_rdata(a_rdata), .pwm_out(a_out)
    );

    pwm_multichan #(.NUM_CH(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_write(b_write),
        .req_addr(b_addr), .req_wdata(b_wdata), .rsp_rdata(b_rdata), .pwm_out(b_out)
    );

    // Driver side: queue an expected value, then the measured one.
    task automatic score(input string tag, input logic [31:0] exp, input logic [31:0] act);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        act_q.push_back(act);
    endtask

    // Monitor: pops and compares every queued result.
    always @(negedge clk) begin
        while (act_q.size() > 0) begin
            string       t;
            logic [31:0] e, a;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s actual=%0h expected=%0h", t, a, e);
            end
        end
    end

    task automatic wr(input int unit, input logic [7:0] addr, input logic [31:0] data);
        if (unit == 0) begin a_valid = 1; a_write = 1; a_addr = addr; a_wdata = data; end
        else           begin b_valid = 1; b_write = 1; b_addr = addr; b_wdata = data; end
        @(posedge clk);
        @(negedge clk);
        a_valid = 0; a_write = 0; b_valid = 0; b_write = 0;
    endtask

    task automatic rd(input int unit, input logic [7:0] addr, output logic [31:0] data);
        if (unit == 0) begin a_valid = 1; a_write = 0; a_addr = addr; end
        else           begin b_valid = 1; b_write = 0; b_addr = addr; end
        @(posedge clk);
        @(negedge clk);
        a_valid = 0; b_valid = 0;
        data = (unit == 0) ? a_rdata : b_rdata;
    endtask

    // Stop then start a channel so that it begins at phase 0.
    task automatic restart(input int unit, input logic [7:0] addr, input logic [31:0] data);
        wr(unit, addr, 32'h0);
        wr(unit, addr, data);
    endtask

    // Counts high samples over n cycles, starting with the current one.
    task automatic measure(input int unit, input int ch, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (unit == 0 ? a_out[ch] : b_out[0]) cnt++;
            @(negedge clk);
        end
    endtask

    // Cycles from the current (high) sample to the next rising edge.
    task automatic rise_gap(input int ch, output int n);
        logic prev;
        prev = a_out[ch];
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            n++;
            if (!prev && a_out[ch]) break;
            prev = a_out[ch];
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input int duty, input int dv);
        return {en, 6'd0, 9'(duty), 3'd0, 13'(dv)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        score("R9 outputs low after reset", 32'd0, {28'd0, a_out});
        rd(0, 8'h30, r);
        score("R9 word reads zero after reset", 32'd0, r);

        // R1: masking and readback latency
        wr(0, 8'h10, 32'hFFFF_FFFF);
        rd(0, 8'h10, r);
        score("R1 readback masks unused bits", 32'h81FF_1FFF, r);
        // R6: writing zero clears the fields
        wr(0, 8'h10, 32'h0);
        rd(0, 8'h10, r);
        score("R6 zero write clears word", 32'h0, r);

        // R5 and R3: start ch0 with count 64, divider 0
        restart(0, 8'h00, cw(1, 64, 0));
        score("R5 output high at phase 0 after start", 32'd1, {31'd0, a_out[0]});
        measure(0, 0, 256, n);
        score("R3 count 64 over one period", 32'd64, n);
        measure(0, 0, 100, n);
        score("R3 first 100 phases", 32'd64, n);

        // R7: mid-period update waits for the boundary
        wr(0, 8'h00, cw(1, 200, 0));
        measure(0, 0, 155, n);
        score("R7 rest of period keeps old count", 32'd0, n);
        measure(0, 0, 256, n);
        score("R7 new count after boundary, still running", 32'd200, n);

        // R6: stop
        wr(0, 8'h00, 32'h0);
        measure(0, 0, 300, n);
        score("R6 stopped channel stays low", 32'd0, n);

        // R3: count edges
        restart(0, 8'h00, cw(1, 0, 0));
        measure(0, 0, 256, n);
        score("R3 count 0 constant low", 32'd0, n);
        restart(0, 8'h00, cw(1, 256, 0));
        measure(0, 0, 256, n);
        score("R3 count 256 constant high", 32'd256, n);
        restart(0, 8'h00, cw(1, 300, 0));
        measure(0, 0, 256, n);
        score("R3 count above 256 constant high", 32'd256, n);

        // R4: divider
        restart(0, 8'h00, cw(1, 10, 2));
        measure(0, 0, 768, n);
        score("R4 divider 2 stretches high time", 32'd30, n);
        restart(0, 8'h00, cw(1, 10, 1));
        rise_gap(0, n);
        score("R4 period with divider 1", 32'd512, n);
        wr(0, 8'h00, 32'h0);

        // R2 and R8: decode and independence
        restart(0, 8'h2C, cw(1, 128, 0));
        rd(0, 8'h20, r);
        score("R2 low address bits ignored", 32'h8080_0000, r);
        restart(0, 8'h10, cw(1, 32, 1));
        measure(0, 1, 512, n);
        score("R8 ch1 count 32 divider 1", 32'd64, n);
        measure(0, 2, 256, n);
        score("R8 ch2 unaffected by ch1", 32'd128, n);
        measure(0, 3, 256, n);
        score("R8 idle ch3 stays low", 32'd0, n);
        rd(0, 8'h30, r);
        score("R8 ch3 word untouched", 32'h0, r);

        // R10 and R2: single-channel build
        wr(1, 8'h10, cw(1, 128, 0));
        measure(1, 0, 256, n);
        score("R2 missing channel write has no effect", 32'd0, n);
        rd(1, 8'h10, r);
        score("R2 missing channel reads zero", 32'h0, r);
        rd(1, 8'h00, r);
        score("R10 channel 0 untouched by missing write", 32'h0, r);
        restart(1, 8'h00, cw(1, 128, 0));
        measure(1, 0, 256, n);
        score("R10 single channel runs", 32'd128, n);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule